// File: doc/BRIEF.md
# Processor Stream Port Access Unit

This unit connects a processor's simple command interface to one outgoing and one incoming 32-bit AXI4-Stream channel. The processor issues put requests, which send a word out, and get requests, which take a word in. Each request is either blocking or non-blocking. A blocking request holds the processor through `stall` until the stream side can accept or supply a word. A non-blocking request always finishes within its fixed latency. When it cannot transfer, it moves nothing and reports the failure through a carry flag.

A control bit travels with every word. On a put, the control bit goes out on the output TLAST. On a get, the input TLAST comes back as the read control bit. The processor raises `req` together with the request fields and holds all of them until the cycle in which `done` is high. Any cycle after that with `req` high starts a new request.

Top module: `stream_port_unit`

## Requirements
- R1: A put presents `wData` on `mTData` and `wCtrl` on `mTLast`. The word sits in a single output slot and is offered with `mTValid` from the cycle after the put completes.
- R2: A blocking put raises `done` in its request cycle when the slot is free, meaning `mTValid` is low or `mTReady` is high. `stall` is low in that cycle.
- R3: While `mTValid` is high and `mTReady` is low, `mTValid`, `mTData` and `mTLast` hold their values into the next cycle.
- R4: A blocking put that finds the slot busy keeps `stall` high and `done` low. `done` rises in the first cycle in which `mTReady` is high, and the new word follows the old one.
- R5: A non-blocking put that finds the slot busy raises `done` in its request cycle. It queues no word, and `carryOut` reads 1 from the next cycle.
- R6: A get that finds `sTValid` high raises `sTReady` for exactly its request cycle. `done` follows in the next cycle, with `rData` and `rCtrl` equal to the consumed `sTData` and `sTLast`.
- R7: A blocking get with no input word keeps `stall` high and `sTReady` low until `sTValid` rises. It then completes as in R6.
- R8: A non-blocking get with no input word raises `done` in its request cycle with `sTReady` low. `carryOut` reads 1 from the next cycle, and `rData` and `rCtrl` keep their previous values.
- R9: `carryOut` changes only at the clock edge that ends a non-blocking request's `done` cycle. A successful non-blocking request clears it, and blocking requests leave it unchanged.
- R10: While synchronous active-high `rst` is applied, `mTValid`, `sTReady`, `done`, `stall` and `carryOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request present, held until `done` |
| isWrite | input | 1 | 1 = put, 0 = get |
| nonBlocking | input | 1 | 1 = non-blocking request |
| wData | input | 32 | Put data word |
| wCtrl | input | 1 | Put control bit |
| done | output | 1 | Request completes this cycle |
| rData | output | 32 | Get data word |
| rCtrl | output | 1 | Get control bit |
| carryOut | output | 1 | Failure flag of the last non-blocking request |
| stall | output | 1 | Processor must hold |
| mTData | output | 32 | Output stream data |
| mTLast | output | 1 | Output stream last flag |
| mTValid | output | 1 | Output stream valid |
| mTReady | input | 1 | Output stream ready |
| sTData | input | 32 | Input stream data |
| sTLast | input | 1 | Input stream last flag |
| sTValid | input | 1 | Input stream valid |
| sTReady | output | 1 | Input stream ready |

## Verification
The hardest case to reach is a busy output slot: a word already held on a stalled channel while a further put arrives. The bench holds `mTReady` low after one put. It then sends a non-blocking put that must disappear and a blocking put that must wait. When `mTReady` is released, a scoreboard fed by the put driver confirms that only the first and third words leave, in order. Reads are covered by placing a word on the input channel before the get, and by withholding a word for several cycles during a blocking get.

// File: rtl/stream_port_pkg.sv
package stream_port_pkg;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic loadOut;    // place processor word in output slot
    logic captureIn;  // latch incoming stream word
  } strobe_t;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_GETDONE = 1'b1
  } ctrl_state_t;
endpackage

// File: rtl/stream_port_ctrl.sv
module stream_port_ctrl
  import stream_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    isWrite,
  input  logic    nonBlocking,
  input  logic    outFree,
  input  logic    sTValid,
  output logic    sTReady,
  output logic    done,
  output logic    stall,
  output logic    carryOut,
  output strobe_t strobes
);
  ctrl_state_t state, stateNext;
  logic carryNext;

  always_comb begin
    stateNext = state;
    carryNext = carryOut;
    done      = 1'b0;
    sTReady   = 1'b0;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (req && isWrite) begin
          strobes.loadOut = outFree;
          done            = outFree || nonBlocking;
          if (nonBlocking) carryNext = !outFree;
        end else if (req) begin
          if (sTValid) begin
            sTReady           = 1'b1;
            strobes.captureIn = 1'b1;
            stateNext         = ST_GETDONE;
          end else if (nonBlocking) begin
            done      = 1'b1;
            carryNext = 1'b1;
          end
        end
      end
      ST_GETDONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
        if (nonBlocking) carryNext = 1'b0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign stall = req && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      carryOut <= 1'b0;
    end else begin
      state    <= stateNext;
      carryOut <= carryNext;
    end
  end

  // R6: a consumed input word completes the get in the following cycle
  a_r6_consume_then_done: assert property (@(posedge clk) disable iff (rst)
    sTReady |=> done);

  // R9: carry moves only when a non-blocking request finishes
  a_r9_carry_quiet: assert property (@(posedge clk) disable iff (rst)
    !(done && nonBlocking) |=> $stable(carryOut));
endmodule

// File: rtl/stream_port_datapath.sv
module stream_port_datapath
  import stream_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wData,
  input  logic              wCtrl,
  input  logic [DATA_W-1:0] sTData,
  input  logic              sTLast,
  input  logic              mTReady,
  output logic              outFree,
  output logic [DATA_W-1:0] mTData,
  output logic              mTLast,
  output logic              mTValid,
  output logic [DATA_W-1:0] rData,
  output logic              rCtrl
);
  assign outFree = !mTValid || mTReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      mTValid <= 1'b0;
      mTData  <= '0;
      mTLast  <= 1'b0;
    end else if (strobes.loadOut) begin
      mTValid <= 1'b1;
      mTData  <= wData;
      mTLast  <= wCtrl;
    end else if (mTReady) begin
      mTValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rData <= '0;
      rCtrl <= 1'b0;
    end else if (strobes.captureIn) begin
      rData <= sTData;
      rCtrl <= sTLast;
    end
  end

  // R3: an offered word is held until the sink takes it
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (mTValid && !mTReady) |=> (mTValid && $stable(mTData) && $stable(mTLast)));
endmodule

// File: rtl/stream_port_unit.sv
module stream_port_unit
  import stream_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              isWrite,
  input  logic              nonBlocking,
  input  logic [DATA_W-1:0] wData,
  input  logic              wCtrl,
  output logic              done,
  output logic [DATA_W-1:0] rData,
  output logic              rCtrl,
  output logic              carryOut,
  output logic              stall,
  output logic [DATA_W-1:0] mTData,
  output logic              mTLast,
  output logic              mTValid,
  input  logic              mTReady,
  input  logic [DATA_W-1:0] sTData,
  input  logic              sTLast,
  input  logic              sTValid,
  output logic              sTReady
);
  strobe_t strobes;
  logic    outFree;

  stream_port_ctrl uCtrl (
    .clk(clk), .rst(rst), .req(req), .isWrite(isWrite),
    .nonBlocking(nonBlocking), .outFree(outFree), .sTValid(sTValid),
    .sTReady(sTReady), .done(done), .stall(stall), .carryOut(carryOut),
    .strobes(strobes)
  );

  stream_port_datapath uData (
    .clk(clk), .rst(rst), .strobes(strobes), .wData(wData), .wCtrl(wCtrl),
    .sTData(sTData), .sTLast(sTLast), .mTReady(mTReady), .outFree(outFree),
    .mTData(mTData), .mTLast(mTLast), .mTValid(mTValid),
    .rData(rData), .rCtrl(rCtrl)
  );

  // R2: a completed blocking put is offered on the stream next cycle
  a_r2_put_offered: assert property (@(posedge clk) disable iff (rst)
    (done && req && isWrite && !nonBlocking) |=> mTValid);

  // R4: a blocking put facing a busy channel holds the processor
  a_r4_busy_stall: assert property (@(posedge clk) disable iff (rst)
    (req && isWrite && !nonBlocking && mTValid && !mTReady) |-> (stall && !done));
endmodule

// File: tb/tb_stream_port_unit.sv
module tb_stream_port_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, isWrite = 1'b0, nonBlocking = 1'b0, wCtrl = 1'b0;
  logic [31:0] wData = '0;
  logic        done, rCtrl, carryOut, stall, mTLast, mTValid, sTReady;
  logic [31:0] rData, mTData;
  logic        mTReady = 1'b0;
  logic [31:0] sTData = '0;
  logic        sTLast = 1'b0, sTValid = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [32:0] expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  stream_port_unit dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic issue(input logic wr, input logic nb, input logic [31:0] d, input logic c);
    @(posedge clk); #1;
    req = 1'b1; isWrite = wr; nonBlocking = nb; wData = d; wCtrl = c;
  endtask

  task automatic release_req();
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // scoreboard monitor: every output handshake must match the next expected word (R1)
  always @(negedge clk) begin
    if (!rst && mTValid && mTReady) begin
      if (expQ.size() == 0) begin
        check("R1 unexpected word", {31'd0, 1'b1}, 32'd0);
      end else begin
        logic [32:0] e;
        e = expQ.pop_front();
        check("R1 data", mTData, e[31:0]);
        check("R1 last", {31'd0, mTLast}, {31'd0, e[32]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    wrapUp();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 mTValid", {31'd0, mTValid}, 0);
    check("R10 sTReady", {31'd0, sTReady}, 0);
    check("R10 done", {31'd0, done}, 0);
    check("R10 stall", {31'd0, stall}, 0);
    check("R10 carry", {31'd0, carryOut}, 0);
    @(posedge clk); #1 rst = 1'b0;

    // R2/R1: blocking put with free slot
    mTReady = 1'b1;
    issue(1, 0, 32'hA1A1_0001, 1);
    @(negedge clk);
    check("R2 done", {31'd0, done}, 1);
    check("R2 stall", {31'd0, stall}, 0);
    expQ.push_back({1'b1, 32'hA1A1_0001});
    release_req();

    // busy slot: R3, R4, R5
    @(posedge clk); #1 mTReady = 1'b0;
    issue(1, 0, 32'hB2B2_0002, 0);
    @(negedge clk);
    check("R2 done B", {31'd0, done}, 1);
    expQ.push_back({1'b0, 32'hB2B2_0002});
    issue(1, 1, 32'hC3C3_0003, 1);
    @(negedge clk);
    check("R5 done nb", {31'd0, done}, 1);
    check("R3 data held", mTData, 32'hB2B2_0002);
    issue(1, 0, 32'hD4D4_0004, 1);
    @(negedge clk);
    check("R5 carry set", {31'd0, carryOut}, 1);
    for (int i = 0; i < 3; i++) begin
      check("R4 stall", {31'd0, stall}, 1);
      check("R4 no done", {31'd0, done}, 0);
      check("R3 data", mTData, 32'hB2B2_0002);
      check("R3 last", {31'd0, mTLast}, 0);
      @(negedge clk);
    end
    @(posedge clk); #1 mTReady = 1'b1;
    @(negedge clk);
    check("R4 done on ready", {31'd0, done}, 1);
    expQ.push_back({1'b1, 32'hD4D4_0004});
    release_req();
    @(negedge clk);
    check("R9 blocking keeps carry", {31'd0, carryOut}, 1);

    // R6: blocking get with data present
    @(posedge clk); #1;
    sTValid = 1'b1; sTData = 32'h1111_AAAA; sTLast = 1'b1;
    issue(0, 0, 0, 0);
    @(negedge clk);
    check("R6 sTReady", {31'd0, sTReady}, 1);
    check("R6 not done yet", {31'd0, done}, 0);
    @(posedge clk); #1 sTValid = 1'b0;
    @(negedge clk);
    check("R6 done", {31'd0, done}, 1);
    check("R6 sTReady one cycle", {31'd0, sTReady}, 0);
    check("R6 rData", rData, 32'h1111_AAAA);
    check("R6 rCtrl", {31'd0, rCtrl}, 1);
    release_req();
    @(negedge clk);
    check("R9 blocking get keeps carry", {31'd0, carryOut}, 1);

    // R8: non-blocking get, no data
    issue(0, 1, 0, 0);
    @(negedge clk);
    check("R8 done", {31'd0, done}, 1);
    check("R8 sTReady", {31'd0, sTReady}, 0);
    release_req();
    @(negedge clk);
    check("R8 carry", {31'd0, carryOut}, 1);
    check("R8 rData kept", rData, 32'h1111_AAAA);
    check("R8 rCtrl kept", {31'd0, rCtrl}, 1);

    // R9: successful non-blocking get clears carry
    @(posedge clk); #1;
    sTValid = 1'b1; sTData = 32'h2222_BBBB; sTLast = 1'b0;
    issue(0, 1, 0, 0);
    @(negedge clk);
    check("R6 nb sTReady", {31'd0, sTReady}, 1);
    @(posedge clk); #1 sTValid = 1'b0;
    @(negedge clk);
    check("R6 nb done", {31'd0, done}, 1);
    check("R6 nb rData", rData, 32'h2222_BBBB);
    check("R6 nb rCtrl", {31'd0, rCtrl}, 0);
    release_req();
    @(negedge clk);
    check("R9 carry cleared", {31'd0, carryOut}, 0);

    // R7: blocking get waits for data
    issue(0, 0, 0, 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R7 stall", {31'd0, stall}, 1);
      check("R7 sTReady low", {31'd0, sTReady}, 0);
      check("R7 no done", {31'd0, done}, 0);
      @(negedge clk);
    end
    @(posedge clk); #1;
    sTValid = 1'b1; sTData = 32'h3333_CCCC; sTLast = 1'b1;
    @(negedge clk);
    check("R7 sTReady on arrival", {31'd0, sTReady}, 1);
    @(posedge clk); #1 sTValid = 1'b0;
    @(negedge clk);
    check("R7 done", {31'd0, done}, 1);
    check("R7 rData", rData, 32'h3333_CCCC);
    release_req();

    // R9: failed nb get then successful nb put clears carry
    issue(0, 1, 0, 0);
    release_req();
    @(negedge clk);
    check("R8 carry again", {31'd0, carryOut}, 1);
    issue(1, 1, 32'hE5E5_0005, 0);
    @(negedge clk);
    check("R2 nb put done", {31'd0, done}, 1);
    expQ.push_back({1'b0, 32'hE5E5_0005});
    release_req();
    @(negedge clk);
    check("R9 nb put clears carry", {31'd0, carryOut}, 0);

    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", expQ.size(), 0);
    wrapUp();
  end
endmodule